// File: doc/BRIEF.md
# Coarse-Tune Search Sequencer

This block searches for lock in a synthesizer whose oscillator range is wider than the phase loop's pull-in range. The block produces a two-bit coarse correction code, and an external converter turns that code into one of four coarse bias levels. Each level is smaller than the pull-in range. While the loop reports no lock, the sequencer steps the code through its four values, one step per dwell tick. A fine ramp elsewhere in the loop sweeps across each level during that dwell.

When lock is reported, the code stops on the value that produced it and keeps that value. An alarm output drives a failure indicator whenever the loop is considered unlocked. The raw lock indication first passes through a configurable synchroniser. A change in the lock level then counts only after it has held for a programmable number of dwell ticks, so a brief excursion cannot start or stop the search.

If lock is later lost and the loss is confirmed, the search resumes from the held code. It does not restart at zero.

Top module: `coarse_search_seq`

## Requirements
- R1: After reset, `code_out` is 2'b00 and `alarm_out` is 1.
- R2: While the filtered state is unlocked and the synchronised lock level is low, each `step_tick` pulse advances `code_out` in the order 00, 01, 10, 11, then back to 00.
- R3: `code_out` changes only in the cycle after a `step_tick` pulse. With no pulse, the code stays fixed.
- R4: While the filtered state is locked, `code_out` holds its value on every tick.
- R5: On a tick where the synchronised lock level is high, the code does not advance. The frozen value is therefore the one present when lock first appeared.
- R6: A new lock level is accepted only on the FILTER_TICKS-th consecutive tick at that level. Any return to the accepted level before then clears the count and leaves `alarm_out` unchanged.
- R7: After a loss of lock is accepted, stepping resumes from the held code. The tick that accepts the loss does not itself advance the code.
- R8: `alarm_out` is 1 exactly when the filtered state is unlocked.
- R9: `lock_in` passes through SYNC_STAGES flip-flops. A level change that is not followed by any tick has no effect on `code_out` or `alarm_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lock_in | input | 1 | Lock indication from the phase detector, 1 = locked |
| step_tick | input | 1 | Single-cycle dwell tick that paces stepping and filtering |
| code_out | output | 2 | Coarse correction code for the bias converter |
| alarm_out | output | 1 | Failure indicator, 1 = unlocked |

## Verification
The bench checks the wrap from 11 to 00 and the exact value on which the code freezes. A design that advanced on the same tick that accepted lock would settle one step past the level that produced lock.

It applies lock excursions one tick shorter than the filter window, in both directions. It then follows each excursion with a full window, which catches a design that fails to clear its stability count.

It confirms that stepping resumes from the held code after a confirmed loss. A design that reset the code on loss, or stepped on the accepting tick, would report the wrong value.

It also checks that lock changes with no ticks leave both outputs unchanged.

// File: rtl/css_pkg.sv
package css_pkg;
   localparam int CODE_W = 2;
   typedef logic [CODE_W-1:0] coarse_code_t;

   function automatic coarse_code_t css_next(input coarse_code_t c);
      return c + coarse_code_t'(1);
   endfunction
endpackage

// File: rtl/css_sync.sv
module css_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_in,
   output logic d_out
);
   if (STAGES < 0) begin : g_bad_stages
      $error("css_sync: STAGES must not be negative");
   end

   if (STAGES == 0) begin : g_bypass
      assign d_out = d_in;
   end else begin : g_chain
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q <= '0;
         else if (STAGES == 1) chain_q <= d_in;
         else chain_q <= {chain_q[STAGES-2:0], d_in};
      end
      assign d_out = chain_q[STAGES-1];
   end
endmodule

// File: rtl/css_filter.sv
module css_filter #(
   parameter int FILTER_TICKS = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic level_in,
   input  logic tick,
   output logic locked
);
   localparam int CNT_W = (FILTER_TICKS < 2) ? 1 : $clog2(FILTER_TICKS);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(FILTER_TICKS - 1);

   if (FILTER_TICKS < 1) begin : g_bad_ticks
      $error("css_filter: FILTER_TICKS must be at least 1");
   end

   logic             state_q;
   logic [CNT_W-1:0] run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= 1'b0;
         run_q   <= '0;
      end else if (level_in == state_q) begin
         run_q <= '0;
      end else if (tick) begin
         if (run_q == LAST) begin
            state_q <= level_in;
            run_q   <= '0;
         end else begin
            run_q <= run_q + CNT_W'(1);
         end
      end
   end

   assign locked = state_q;

   // R6: the filtered state moves only on a tick
   assert_state_on_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(state_q) |-> $past(tick));
   // R6: the filtered state moves only toward the synchronised level
   assert_state_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(state_q) |-> state_q == $past(level_in));
endmodule

// File: rtl/css_stepper.sv
module css_stepper
   import css_pkg::*;
#(
   parameter coarse_code_t RESET_CODE = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  logic         raw_lock,
   input  logic         locked,
   output coarse_code_t code
);
   coarse_code_t code_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) code_q <= RESET_CODE;
      else if (tick && !raw_lock && !locked) code_q <= css_next(code_q);
   end

   assign code = code_q;

   // R3: the code moves only after a tick
   assert_step_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(code_q) |-> $past(tick));
   // R2: each move is a single increment with wrap
   assert_step_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(code_q) |-> code_q == css_next($past(code_q)));
   // R4: held while locked
   assert_hold_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $past(locked) |-> $stable(code_q));
   // R5: paused while the synchronised lock is high
   assert_pause_raw_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $past(raw_lock) |-> $stable(code_q));
endmodule

// File: rtl/coarse_search_seq.sv
module coarse_search_seq
   import css_pkg::*;
#(
   parameter int SYNC_STAGES  = 2,
   parameter int FILTER_TICKS = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       lock_in,
   input  logic       step_tick,
   output logic [1:0] code_out,
   output logic       alarm_out
);
   logic         lock_s;
   logic         locked_f;
   coarse_code_t code_w;

   css_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  (lock_in),
      .d_out (lock_s)
   );

   css_filter #(.FILTER_TICKS(FILTER_TICKS)) u_filter (
      .clk      (clk),
      .rst_n    (rst_n),
      .level_in (lock_s),
      .tick     (step_tick),
      .locked   (locked_f)
   );

   css_stepper #(.RESET_CODE('0)) u_step (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (step_tick),
      .raw_lock (lock_s),
      .locked   (locked_f),
      .code     (code_w)
   );

   assign code_out  = code_w;
   assign alarm_out = ~locked_f;

   // R7: the tick that accepts a loss leaves the code where it was
   assert_resume_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(alarm_out) |-> $stable(code_out));
   // R8: alarm rises or falls only on a tick
   assert_alarm_on_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(alarm_out) |-> $past(step_tick));
endmodule

// File: tb/sim_coarse_search_seq.sv
module sim_coarse_search_seq;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       lock_in = 1'b0;
   logic       step_tick = 1'b0;
   logic [1:0] code_out;
   logic       alarm_out;

   int errors = 0;
   int checks = 0;
   int cycles = 0;

   typedef struct {
      logic [1:0] code;
      logic       alarm;
      string      tag;
   } exp_t;
   exp_t sb_q[$];

   always #5 clk = ~clk;

   coarse_search_seq #(.SYNC_STAGES(2), .FILTER_TICKS(3)) u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .lock_in   (lock_in),
      .step_tick (step_tick),
      .code_out  (code_out),
      .alarm_out (alarm_out)
   );

   // monitor: one comparison per cycle, 2 ns after the update edge
   always @(posedge clk) begin
      #2;
      if (sb_q.size() > 0) begin
         exp_t e;
         e = sb_q.pop_front();
         checks++;
         if (code_out !== e.code || alarm_out !== e.alarm) begin
            errors++;
            $display("FAIL %s: code=%b alarm=%b expected code=%b alarm=%b",
                     e.tag, code_out, alarm_out, e.code, e.alarm);
         end
      end
   end

   task automatic push(input logic [1:0] c, input logic a, input string tag);
      exp_t e;
      e.code = c; e.alarm = a; e.tag = tag;
      sb_q.push_back(e);
   endtask

   task automatic tick(input logic [1:0] c, input logic a, input string tag);
      step_tick = 1'b1;
      push(c, a, tag);
      @(negedge clk);
      step_tick = 1'b0;
   endtask

   task automatic idle(input logic [1:0] c, input logic a, input string tag);
      push(c, a, tag);
      @(negedge clk);
   endtask

   task automatic set_lock(input logic v);
      lock_in = v;
      repeat (3) @(negedge clk);
   endtask

   initial begin
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      idle(2'b00, 1'b1, "R1 reset state");
      // R2: ordered scan with wrap
      tick(2'b01, 1'b1, "R2 step1");
      tick(2'b10, 1'b1, "R2 step2");
      tick(2'b11, 1'b1, "R2 step3");
      tick(2'b00, 1'b1, "R2 wrap");
      tick(2'b01, 1'b1, "R2 step5");
      idle(2'b01, 1'b1, "R3 no tick");
      idle(2'b01, 1'b1, "R3 no tick");
      // R9: lock rises, no ticks
      set_lock(1'b1);
      idle(2'b01, 1'b1, "R9 no tick after change");
      tick(2'b01, 1'b1, "R5 pause tick1");
      tick(2'b01, 1'b1, "R5 pause tick2");
      tick(2'b01, 1'b0, "R6 lock accepted");
      tick(2'b01, 1'b0, "R4 held");
      tick(2'b01, 1'b0, "R4 held");
      // short loss excursion
      set_lock(1'b0);
      tick(2'b01, 1'b0, "R6 short loss1");
      tick(2'b01, 1'b0, "R6 short loss2");
      set_lock(1'b1);
      tick(2'b01, 1'b0, "R6 excursion cleared");
      // confirmed loss
      set_lock(1'b0);
      tick(2'b01, 1'b0, "R6 loss1");
      tick(2'b01, 1'b0, "R6 loss2");
      tick(2'b01, 1'b1, "R7 loss accepted no step");
      tick(2'b10, 1'b1, "R7 resume");
      tick(2'b11, 1'b1, "R7 resume");
      // short lock excursion while unlocked
      set_lock(1'b1);
      tick(2'b11, 1'b1, "R5 glitch pause1");
      tick(2'b11, 1'b1, "R5 glitch pause2");
      set_lock(1'b0);
      tick(2'b00, 1'b1, "R6 glitch rejected wrap");
      // full window after cleared count
      set_lock(1'b1);
      tick(2'b00, 1'b1, "R6 window1");
      tick(2'b00, 1'b1, "R6 window2");
      tick(2'b00, 1'b0, "R8 alarm drops");
      set_lock(1'b0);
      idle(2'b00, 1'b0, "R9 loss no tick");
      wait (sb_q.size() == 0);
      repeat (2) @(negedge clk);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 5000) begin
         errors++;
         checks++;
         $display("FAIL watchdog: cycles=%0d expected completion", cycles);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule